// File: doc/BRIEF.md
# Serial PCM Slot Controller for a Telephony Filter/Codec

This block is the digital half of one filter/codec channel on a 2.048 MHz serial time-division bus with a 125 µs frame. An active-low frame strobe opens an eight-bit window. During that window the block does three things at once. It shifts one PCM byte out to the bus, shifts one PCM byte in for the decoder, and captures a serial control byte.

The control byte lands in one of two eight-bit control registers. In dual mode the register-select pin steers the byte, so a frame can carry two windows, one for each register. In single mode every byte goes to the first register. The first register is decoded into a transmit gain step, a receive gain step and a function mode: normal, digital loopback, analog loopback or powerdown. The second register drives six uncommitted control outputs directly. A separate forced-powerdown request parks the block for a fixed number of bit clocks. During that time it ignores the bus.

The block is built around a four-state controller: `ST_IDLE`, `ST_SHIFT`, `ST_HOLD` and `ST_PDOWN`. Its transitions are:

- open: `ST_IDLE` to `ST_SHIFT`, when the strobe is low and no forced powerdown is requested.
- abort: `ST_SHIFT` to `ST_IDLE`, when the strobe rises before the eighth bit.
- last: `ST_SHIFT` to `ST_HOLD`, on the eighth bit.
- release: `ST_HOLD` to `ST_IDLE`, when the strobe rises.
- park: `ST_IDLE` to `ST_PDOWN`, on a forced powerdown request.
- resume: `ST_PDOWN` to `ST_IDLE`, when the hold count expires.

Top module: `pcm_slot_ctrl`

## Requirements
- R1: After reset both control registers are zero. So `tx_gain`, `rx_gain`, `func_mode`, `ctl_out` and `dec_byte` are all zero, and `pwr_down` and `pcm_sdo_oe` are low.
- R2: A window opens at the first rising clock edge at which `frame_en_n` is low while the block is idle. The control and PCM inputs are sampled on that edge and the next seven edges, most significant bit first.
- R3: `pcm_sdo_oe` is high from the moment the window opens until the eighth sampling edge. `pcm_sdo` shows the most significant bit before the first edge and the next bit after each edge. After the eighth edge `pcm_sdo_oe` is low until the strobe has gone high and a new window opens.
- R4: In dual mode (`dual_mode`=1) a completed control byte loads register A when `reg_sel` is 0 and register B when `reg_sel` is 1.
- R5: In single mode (`dual_mode`=0) a completed control byte always loads register A, and register B keeps its value.
- R6: A register is written only on the eighth sampling edge. A window whose strobe rises earlier leaves both registers and `dec_byte` unchanged.
- R7: `tx_gain` is register A bits 1:0 and `rx_gain` is register A bits 4:3. `func_mode` is register A bits 6:5, encoded as follows: 00 normal, 01 digital loopback, 10 analog loopback, 11 powerdown.
- R8: `ctl_out` equals register B bits 5:0.
- R9: When `func_mode` is 01 at the moment a window opens, that window transmits the last received PCM byte instead of `enc_byte`.
- R10: `dec_byte` holds the PCM byte of the last completed window. It is updated on that window's eighth edge.
- R11: `pwr_down` is high while `func_mode` is 11.
- R12: `pd_force` is sampled high at an edge while the block is idle. From that edge `pwr_down` stays high for exactly 25 clock cycles. While it is high, windows are ignored: `pcm_sdo_oe` stays low and no register or `dec_byte` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_en_n | input | 1 | Active-low window strobe |
| reg_sel | input | 1 | Register select in dual mode: 0 selects A, 1 selects B |
| dual_mode | input | 1 | 1 selects two-register mode, 0 selects single-register mode |
| pd_force | input | 1 | Forced powerdown request |
| ctl_sdi | input | 1 | Serial control data in |
| pcm_sdi | input | 1 | Serial PCM data in |
| enc_byte | input | 8 | Encoder byte to transmit |
| pcm_sdo | output | 1 | Serial PCM data out |
| pcm_sdo_oe | output | 1 | Output enable for `pcm_sdo`; low means high impedance |
| dec_byte | output | 8 | Last received PCM byte |
| tx_gain | output | 2 | Transmit gain step code |
| rx_gain | output | 2 | Receive gain step code |
| func_mode | output | 2 | Function mode code |
| ctl_out | output | 6 | Uncommitted control outputs |
| pwr_down | output | 1 | Powerdown indication |

## Verification
A bit counter that is off by one shows up within the same window. The output enable drops an edge early or late, and the captured control byte is shifted, which is visible on the decoded gain pins straight after the window. Misrouting between the two registers appears on `ctl_out` or the gain pins in the window that caused it. A stale loopback byte shows up only one window later, as the wrong serial output byte. A wrong powerdown count is seen as `pwr_down` falling early or late within 25 cycles of the request.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_HOLD  = 2'd2,
        ST_PDOWN = 2'd3
    } slot_state_e;

    typedef enum logic [1:0] {
        FN_NORMAL   = 2'b00,
        FN_DIG_LOOP = 2'b01,
        FN_ANA_LOOP = 2'b10,
        FN_PWRDN    = 2'b11
    } func_e;

    localparam int TXG_LSB  = 0;
    localparam int RXG_LSB  = 3;
    localparam int FUNC_LSB = 5;

endpackage

// File: rtl/pcm_slot_fsm.sv
module pcm_slot_fsm
    import pcm_slot_pkg::*;
#(
    parameter int BITS      = 8,
    parameter int PD_CYCLES = 25
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        win,
    input  logic        pd_force,
    output slot_state_e st,
    output logic        shift_en,
    output logic        first_bit,
    output logic        commit,
    output logic        pd_active
);
    localparam int CW = (BITS > 1) ? $clog2(BITS) : 1;
    localparam int PW = $clog2(PD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(BITS - 1);

    slot_state_e    st_n;
    logic [CW-1:0]  bit_cnt, bit_cnt_n;
    logic [PW-1:0]  pd_cnt, pd_cnt_n;

    // next-state logic
    always_comb begin
        st_n      = st;
        bit_cnt_n = bit_cnt;
        pd_cnt_n  = pd_cnt;
        unique case (st)
            ST_IDLE: begin
                if (pd_force) begin
                    st_n     = ST_PDOWN;
                    pd_cnt_n = PW'(PD_CYCLES - 1);
                end else if (win) begin
                    st_n      = ST_SHIFT;
                    bit_cnt_n = CW'(1);
                end
            end
            ST_SHIFT: begin
                if (!win) begin
                    st_n = ST_IDLE;
                end else if (bit_cnt == LAST) begin
                    st_n = ST_HOLD;
                end else begin
                    bit_cnt_n = bit_cnt + CW'(1);
                end
            end
            ST_HOLD: begin
                if (!win) st_n = ST_IDLE;
            end
            ST_PDOWN: begin
                if (pd_cnt == '0) st_n = ST_IDLE;
                else              pd_cnt_n = pd_cnt - PW'(1);
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            bit_cnt <= '0;
            pd_cnt  <= '0;
        end else begin
            st      <= st_n;
            bit_cnt <= bit_cnt_n;
            pd_cnt  <= pd_cnt_n;
        end
    end

    // outputs
    always_comb begin
        shift_en  = 1'b0;
        first_bit = 1'b0;
        commit    = 1'b0;
        pd_active = 1'b0;
        unique case (st)
            ST_IDLE: begin
                first_bit = win && !pd_force;
                shift_en  = win && !pd_force;
            end
            ST_SHIFT: begin
                shift_en = win;
                commit   = win && (bit_cnt == LAST);
            end
            ST_HOLD:  ;
            ST_PDOWN: pd_active = 1'b1;
            default:  ;
        endcase
    end

    // R12
    pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PDOWN && pd_cnt != '0) |=> (st == ST_PDOWN));

    // R12
    pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PDOWN) |-> (!shift_en && !commit));

endmodule

// File: rtl/pcm_slot_serdes.sv
module pcm_slot_serdes #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         first_bit,
    input  logic         commit,
    input  logic         loop_sel,
    input  logic         ctl_sdi,
    input  logic         pcm_sdi,
    input  logic [W-1:0] enc_byte,
    output logic [W-1:0] ctl_word,
    output logic [W-1:0] dec_byte,
    output logic         sdo_bit
);
    logic [W-1:0] ctl_sh, pcm_sh, tx_sh, loop_q, tx_src;

    assign tx_src   = loop_sel ? loop_q : enc_byte;
    assign ctl_word = {ctl_sh[W-2:0], ctl_sdi};
    assign sdo_bit  = first_bit ? tx_src[W-1] : tx_sh[W-1];
    assign dec_byte = loop_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_sh <= '0;
            pcm_sh <= '0;
            tx_sh  <= '0;
            loop_q <= '0;
        end else begin
            if (shift_en) begin
                ctl_sh <= {ctl_sh[W-2:0], ctl_sdi};
                pcm_sh <= {pcm_sh[W-2:0], pcm_sdi};
            end
            if (first_bit)     tx_sh <= {tx_src[W-2:0], 1'b0};
            else if (shift_en) tx_sh <= {tx_sh[W-2:0], 1'b0};
            if (commit)        loop_q <= {pcm_sh[W-2:0], pcm_sdi};
        end
    end

endmodule

// File: rtl/pcm_ctl_regs.sv
module pcm_ctl_regs
    import pcm_slot_pkg::*;
#(
    parameter int W    = 8,
    parameter int NCTL = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit,
    input  logic            dual_mode,
    input  logic            reg_sel,
    input  logic [W-1:0]    word,
    output logic [1:0]      tx_gain,
    output logic [1:0]      rx_gain,
    output func_e           mode,
    output logic [NCTL-1:0] ctl_out
);
    logic [W-1:0] reg_a, reg_b;
    logic         to_b;

    assign to_b = dual_mode && reg_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_a <= '0;
            reg_b <= '0;
        end else if (commit) begin
            if (to_b) reg_b <= word;
            else      reg_a <= word;
        end
    end

    assign tx_gain = reg_a[TXG_LSB +: 2];
    assign rx_gain = reg_a[RXG_LSB +: 2];
    assign mode    = func_e'(reg_a[FUNC_LSB +: 2]);

    for (genvar i = 0; i < NCTL; i++) begin : g_drv
        assign ctl_out[i] = reg_b[i];
    end

    // R5
    b_single_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !dual_mode) |=> $stable(reg_b));

endmodule

// File: rtl/pcm_slot_ctrl.sv
module pcm_slot_ctrl
    import pcm_slot_pkg::*;
#(
    parameter int W         = 8,
    parameter int NCTL      = 6,
    parameter int PD_CYCLES = 25
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_en_n,
    input  logic            reg_sel,
    input  logic            dual_mode,
    input  logic            pd_force,
    input  logic            ctl_sdi,
    input  logic            pcm_sdi,
    input  logic [W-1:0]    enc_byte,
    output logic            pcm_sdo,
    output logic            pcm_sdo_oe,
    output logic [W-1:0]    dec_byte,
    output logic [1:0]      tx_gain,
    output logic [1:0]      rx_gain,
    output logic [1:0]      func_mode,
    output logic [NCTL-1:0] ctl_out,
    output logic            pwr_down
);
    slot_state_e st;
    logic        shift_en, first_bit, commit, pd_active, sdo_bit;
    logic [W-1:0] ctl_word;
    func_e       mode;

    pcm_slot_fsm #(.BITS(W), .PD_CYCLES(PD_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .win(!frame_en_n), .pd_force(pd_force),
        .st(st), .shift_en(shift_en), .first_bit(first_bit),
        .commit(commit), .pd_active(pd_active)
    );

    pcm_slot_serdes #(.W(W)) u_serdes (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .first_bit(first_bit),
        .commit(commit), .loop_sel(mode == FN_DIG_LOOP),
        .ctl_sdi(ctl_sdi), .pcm_sdi(pcm_sdi), .enc_byte(enc_byte),
        .ctl_word(ctl_word), .dec_byte(dec_byte), .sdo_bit(sdo_bit)
    );

    pcm_ctl_regs #(.W(W), .NCTL(NCTL)) u_regs (
        .clk(clk), .rst_n(rst_n), .commit(commit), .dual_mode(dual_mode),
        .reg_sel(reg_sel), .word(ctl_word), .tx_gain(tx_gain),
        .rx_gain(rx_gain), .mode(mode), .ctl_out(ctl_out)
    );

    assign pcm_sdo_oe = shift_en;
    assign pcm_sdo    = shift_en ? sdo_bit : 1'b0;
    assign func_mode  = mode;
    assign pwr_down   = pd_active || (mode == FN_PWRDN);

    // R3
    float_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !pcm_sdo_oe);

    // R6
    a_commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({tx_gain, rx_gain, func_mode}) |-> $past(commit));

    // R10
    dec_commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dec_byte) |-> $past(commit));

    // R12
    pd_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_active |-> !pcm_sdo_oe);

endmodule

// File: tb/sim_pcm_slot_ctrl.sv
module sim_pcm_slot_ctrl;
    logic clk = 1'b0, rst_n = 1'b0;
    logic frame_en_n = 1'b1, reg_sel = 1'b0, dual_mode = 1'b1, pd_force = 1'b0;
    logic ctl_sdi = 1'b0, pcm_sdi = 1'b0;
    logic [7:0] enc_byte = 8'h00;
    logic pcm_sdo, pcm_sdo_oe, pwr_down;
    logic [7:0] dec_byte;
    logic [1:0] tx_gain, rx_gain, func_mode;
    logic [5:0] ctl_out;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pcm_slot_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .frame_en_n(frame_en_n), .reg_sel(reg_sel),
        .dual_mode(dual_mode), .pd_force(pd_force), .ctl_sdi(ctl_sdi),
        .pcm_sdi(pcm_sdi), .enc_byte(enc_byte), .pcm_sdo(pcm_sdo),
        .pcm_sdo_oe(pcm_sdo_oe), .dec_byte(dec_byte), .tx_gain(tx_gain),
        .rx_gain(rx_gain), .func_mode(func_mode), .ctl_out(ctl_out),
        .pwr_down(pwr_down)
    );

    // {dual, sel, ctl, pcm_in, enc, exp_sdo, exp_txg, exp_rxg, exp_mode, exp_ctl_out}
    localparam logic [45:0] VEC [9] = '{
        {1'b1, 1'b0, 8'h1B, 8'hC3, 8'hA5, 8'hA5, 2'd3, 2'd3, 2'd0, 6'h00},
        {1'b1, 1'b1, 8'h2D, 8'h3C, 8'h96, 8'h96, 2'd3, 2'd3, 2'd0, 6'h2D},
        {1'b0, 1'b1, 8'h0A, 8'h11, 8'h7E, 8'h7E, 2'd2, 2'd1, 2'd0, 6'h2D},
        {1'b1, 1'b0, 8'h20, 8'h5A, 8'h0F, 8'h0F, 2'd0, 2'd0, 2'd1, 6'h2D},
        {1'b1, 1'b1, 8'h3F, 8'h81, 8'hF0, 8'h5A, 2'd0, 2'd0, 2'd1, 6'h3F},
        {1'b1, 1'b0, 8'h40, 8'hE7, 8'h33, 8'h81, 2'd0, 2'd0, 2'd2, 6'h3F},
        {1'b1, 1'b0, 8'h60, 8'h00, 8'hCC, 8'hCC, 2'd0, 2'd0, 2'd3, 6'h3F},
        {1'b1, 1'b0, 8'h00, 8'hFF, 8'h55, 8'h55, 2'd0, 2'd0, 2'd0, 6'h3F},
        {1'b1, 1'b1, 8'hC0, 8'h24, 8'h42, 8'h42, 2'd0, 2'd0, 2'd0, 6'h00}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run_win(input logic dual, input logic sel, input logic [7:0] ctl,
                           input logic [7:0] pcm, input logic [7:0] enc,
                           input int nbits, output logic [7:0] got, output int oe_low);
        got = 8'h00;
        oe_low = 0;
        @(negedge clk);
        dual_mode = dual;
        reg_sel = sel;
        enc_byte = enc;
        frame_en_n = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            ctl_sdi = ctl[7-i];
            pcm_sdi = pcm[7-i];
            #1;
            got[7-i] = pcm_sdo;
            if (!pcm_sdo_oe) oe_low++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        int oe_low;
        logic [1:0] pre_tx, pre_rx, pre_md;
        logic [7:0] pre_dec;
        int pd_cnt;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 gains/mode", {tx_gain, rx_gain, func_mode}, 0);
        chk("R1 ctl_out", ctl_out, 0);
        chk("R1 dec_byte", dec_byte, 0);
        chk("R1 pwr_down/oe", {pwr_down, pcm_sdo_oe}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 9; v++) begin
            run_win(VEC[v][45], VEC[v][44], VEC[v][43:36], VEC[v][35:28],
                    VEC[v][27:20], 8, got, oe_low);
            chk("R2 R3 R9 serial out byte", got, VEC[v][19:12]);
            chk("R3 oe high through window", oe_low, 0);
            chk("R3 float after eighth bit", pcm_sdo_oe, 0);
            chk("R4 R5 R7 gains/mode", {tx_gain, rx_gain, func_mode}, VEC[v][11:6]);
            chk("R8 R5 ctl_out", ctl_out, VEC[v][5:0]);
            chk("R10 dec_byte", dec_byte, VEC[v][35:28]);
            chk("R11 pwr_down", pwr_down, (VEC[v][7:6] == 2'd3) ? 1 : 0);
            frame_en_n = 1'b1;
            @(negedge clk);
        end

        // R6 aborted window leaves state unchanged
        pre_tx = tx_gain; pre_rx = rx_gain; pre_md = func_mode; pre_dec = dec_byte;
        run_win(1'b1, 1'b0, 8'h7B, 8'h99, 8'h00, 5, got, oe_low);
        frame_en_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6 abort keeps reg A", {tx_gain, rx_gain, func_mode}, {pre_tx, pre_rx, pre_md});
        chk("R6 abort keeps dec_byte", dec_byte, pre_dec);

        // R12 forced powerdown
        pre_tx = tx_gain; pre_rx = rx_gain; pre_md = func_mode; pre_dec = dec_byte;
        pd_force = 1'b1;
        @(negedge clk);
        pd_force = 1'b0;
        pd_cnt = 0;
        oe_low = 0;
        for (int c = 0; c < 40; c++) begin
            if (c == 3) begin
                frame_en_n = 1'b0; reg_sel = 1'b0; dual_mode = 1'b1;
                ctl_sdi = 1'b1; pcm_sdi = 1'b1;
            end
            if (c == 12) frame_en_n = 1'b1;
            #1;
            if (pwr_down) pd_cnt++;
            if (pcm_sdo_oe) oe_low++;
            @(negedge clk);
        end
        chk("R12 powerdown length", pd_cnt, 25);
        chk("R12 no drive during powerdown", oe_low, 0);
        chk("R12 reg A untouched", {tx_gain, rx_gain, func_mode}, {pre_tx, pre_rx, pre_md});
        chk("R12 dec_byte untouched", dec_byte, pre_dec);

        // after resume the slot works again
        run_win(1'b1, 1'b0, 8'h19, 8'h6E, 8'hB4, 8, got, oe_low);
        chk("R2 R7 resume load", {tx_gain, rx_gain, func_mode}, {2'd1, 2'd3, 2'd0});
        chk("R2 resume serial out", got, 8'hB4);
        chk("R10 resume dec_byte", dec_byte, 8'h6E);
        frame_en_n = 1'b1;
        @(negedge clk);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule